// File: doc/BRIEF.md
# Port-Write Receive Controller

This block accepts maintenance port-write packets from a serial interconnect receiver and saves each one into a single-entry buffer in system memory. Each packet is sixteen 32-bit words long. The words are written in order through a plain memory write port, starting at a programmable base address. Software controls the block through four 32-bit registers: a mode register, a status register, and a two-part buffer base address.

The queue holds only one entry. Once a packet has been stored, the queue stays locked until software issues an explicit clear-queue command. Any port-write that arrives while the queue is locked is thrown away, flagged and counted. A packet that carries a transaction error is abandoned and raises an error flag. Software can clear that flag only while the unit is disabled.

The block drives one interrupt output. It also drives a top-level summary word, which merges the port-write interrupt with error indications from the message unit and from two ports.

Top module: `pw_receiver`

## Requirements
- R1: After reset, every register reads 0, no interrupt is raised and no memory write occurs.
- R2: When the unit is enabled and the queue is empty, an accepted 16-word packet is written word i at byte address base + 4*i. The base is {extended base, base low}. Words are written in arrival order, on the cycle each word is presented.
- R3: After the 16th word is stored, status bit 20 (queue full) and bit 4 (full interrupt) are set. While the queue is full, a new packet is not written to memory, it sets status bit 3 (discarded) and it increments the drop counter.
- R4: Writing the mode register with bit 1 set clears the queue-full flag. Bit 1 always reads back as 0, and the next packet is accepted again.
- R5: Status bits 4 and 3 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R6: If a word of an accepted packet has the error input set, status bit 7 (transaction error) is set. That word and the rest of the packet are not written, and the queue-full flag stays clear.
- R7: Status bit 7 is cleared by writing 1 to it only while mode bit 0 (enable) is 0. The same write while the unit is enabled has no effect.
- R8: The interrupt output is high when status bit 4 and mode bit 8 are both set, or when status bit 7 and mode bit 5 are both set.
- R9: The base low register (address 2) and the extended base register (address 3) take writes only while the unit is disabled. They read back what was written. The mode register is at address 0 and the status register at address 1.
- R10: While the unit is disabled, incoming packets are ignored: there are no memory writes and no status flags change.
- R11: In the summary output, bit 0 is the interrupt output, bit 1 is the message-unit error input, and bits 31 and 30 are the port 1 and port 2 error inputs.
- R12: Status bit 2 (busy) is 1 while a packet is partway through reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 base low, 3 extended base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pkt_valid | input | 1 | Packet word valid |
| pkt_data | input | 32 | Packet word |
| pkt_err | input | 1 | Transaction error on this word |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 32+EXT_W | Buffer byte address |
| mem_wdata | output | 32 | Buffer write data |
| irq | output | 1 | Port-write interrupt |
| port1_err | input | 1 | Port 1 error indication |
| port2_err | input | 1 | Port 2 error indication |
| msg_err | input | 1 | Message-unit error indication |
| summary | output | 32 | Interrupt summary word |
| drop_cnt | output | CNT_W | Saturating count of discarded packets |

## Verification
The bench sends a second packet while the queue is still full. A design that did not lock the queue would overwrite the stored message, and the scoreboard would see memory writes it did not expect. The bench tries to clear the transaction error while the unit is enabled. A design that allowed this clear would drop the error early. The bench injects an error in the middle of a packet. A design that kept writing after the error, or that marked the queue full anyway, would be caught. The bench also writes a new base while the unit is enabled and sends packets while the unit is disabled. These catch a base that moves during use and flags that change while the unit is off.

// File: rtl/pw_receiver.sv
module pw_receiver #(
  parameter int WORDS = 16,
  parameter int EXT_W = 4,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 pkt_valid,
  input  logic [31:0]          pkt_data,
  input  logic                 pkt_err,
  output logic                 mem_we,
  output logic [31+EXT_W:0]    mem_addr,
  output logic [31:0]          mem_wdata,
  output logic                 irq,
  input  logic                 port1_err,
  input  logic                 port2_err,
  input  logic                 msg_err,
  output logic [31:0]          summary,
  output logic [CNT_W-1:0]     drop_cnt
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int AW    = 32 + EXT_W;

  logic en, eie, qfie, sen;
  logic qf, te, qfi, pwd;
  logic capture;
  logic [31:0]      base_lo;
  logic [EXT_W-1:0] base_hi;
  logic [IDX_W-1:0] idx;

  wire busy       = idx != '0;
  wire last       = idx == IDX_W'(WORDS - 1);
  wire start      = pkt_valid && !busy;
  wire take_first = start && en && !qf;
  wire drop_first = start && en && qf;
  wire live       = take_first || (busy && capture && en);
  wire err_word   = pkt_valid && live && pkt_err;
  wire mode_wr    = reg_we && reg_addr == 2'd0;
  wire stat_wr    = reg_we && reg_addr == 2'd1;

  assign mem_we    = pkt_valid && live && !pkt_err;
  assign mem_wdata = pkt_data;
  assign mem_addr  = {base_hi, base_lo} + AW'({idx, 2'b00});
  assign irq       = (qfi && qfie) || (te && eie);

  always_comb begin
    summary     = '0;
    summary[0]  = irq;
    summary[1]  = msg_err;
    summary[31] = port1_err;
    summary[30] = port2_err;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[0]  = en;
        reg_rdata[5]  = eie;
        reg_rdata[8]  = qfie;
        reg_rdata[20] = sen;
      end
      2'd1: begin
        reg_rdata[20] = qf;
        reg_rdata[7]  = te;
        reg_rdata[4]  = qfi;
        reg_rdata[3]  = pwd;
        reg_rdata[2]  = busy;
      end
      2'd2: reg_rdata = base_lo;
      default: reg_rdata[EXT_W-1:0] = base_hi;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; eie <= 1'b0; qfie <= 1'b0; sen <= 1'b0;
      qf <= 1'b0; te <= 1'b0; qfi <= 1'b0; pwd <= 1'b0;
      capture <= 1'b0; idx <= '0;
      base_lo <= '0; base_hi <= '0; drop_cnt <= '0;
    end else begin
      if (mode_wr) begin
        en   <= reg_wdata[0];
        eie  <= reg_wdata[5];
        qfie <= reg_wdata[8];
        sen  <= reg_wdata[20];
      end
      if (reg_we && !en && reg_addr == 2'd2) base_lo <= reg_wdata;
      if (reg_we && !en && reg_addr == 2'd3) base_hi <= reg_wdata[EXT_W-1:0];

      if (pkt_valid && (busy || en)) idx <= IDX_W'(idx + 1'b1);
      if (start)                 capture <= take_first && !pkt_err;
      else if (err_word || !en)  capture <= 1'b0;

      if (mem_we && last)                 qf <= 1'b1;
      else if (mode_wr && reg_wdata[1])   qf <= 1'b0;

      if (mem_we && last)                 qfi <= 1'b0 | 1'b1;
      else if (stat_wr && reg_wdata[4])   qfi <= 1'b0;

      if (drop_first)                     pwd <= 1'b1;
      else if (stat_wr && reg_wdata[3])   pwd <= 1'b0;

      if (err_word)                       te <= 1'b1;
      else if (stat_wr && reg_wdata[7] && !en) te <= 1'b0;

      if (drop_first && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  assert_no_write_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !qf);
  assert_full_raises_irq_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qf) |-> qfi);
  assert_cq_unlocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && reg_wdata[1] && !(mem_we && last)) |=> !qf);
  assert_err_clear_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(te) |-> !$past(en));
  assert_write_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> en);
  assert_err_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_err) |-> !mem_we);
endmodule

// File: tb/pw_receiver_bench.sv
module pw_receiver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pkt_valid = 1'b0;
  logic [31:0] pkt_data = '0;
  logic pkt_err = 1'b0;
  logic mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic irq;
  logic port1_err = 1'b0, port2_err = 1'b0, msg_err = 1'b0;
  logic [31:0] summary;
  logic [7:0] drop_cnt;

  int checks = 0;
  int failures = 0;
  logic [35:0] exp_addr[$];
  logic [31:0] exp_data[$];

  always #5 clk = ~clk;

  pw_receiver u_pw_receiver (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .pkt_err(pkt_err), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq),
    .port1_err(port1_err), .port2_err(port2_err), .msg_err(msg_err),
    .summary(summary), .drop_cnt(drop_cnt));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R2/R3/R6/R10 unexpected write", {28'd0, mem_addr}, 64'd0);
      end else begin
        logic [35:0] ea;
        logic [31:0] ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(mem_addr == ea, "R2 write address", {28'd0, mem_addr}, {28'd0, ea});
        chk(mem_wdata == ed, "R2 write data", {32'd0, mem_wdata}, {32'd0, ed});
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [31:0] e, input string req);
    reg_addr = a; #1;
    chk(reg_rdata == e, req, {32'd0, reg_rdata}, {32'd0, e});
    reg_addr = 2'd1;
  endtask

  task automatic send_packet(input logic [35:0] base, input logic [31:0] seed,
                             input bit accept, input int err_at);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      pkt_valid = 1'b1;
      pkt_data  = seed + 32'(i);
      pkt_err   = (i == err_at);
      if (accept && (err_at < 0 || i < err_at)) begin
        exp_addr.push_back(base + 36'(4 * i));
        exp_data.push_back(seed + 32'(i));
      end
      if (i == 5 && accept) begin
        reg_addr = 2'd1; #1;
        chk(reg_rdata[2] == 1'b1, "R12 busy mid packet", {63'd0, reg_rdata[2]}, 64'd1);
      end
    end
    @(posedge clk); #1;
    pkt_valid = 1'b0; pkt_err = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    read_chk(2'd0, 32'h0, "R1 mode reset");
    read_chk(2'd1, 32'h0, "R1 status reset");
    read_chk(2'd2, 32'h0, "R1 base reset");
    chk(irq == 1'b0, "R1 irq reset", {63'd0, irq}, 64'd0);

    reg_write(2'd2, 32'h0000_1000);
    reg_write(2'd3, 32'h0000_0003);
    read_chk(2'd2, 32'h0000_1000, "R9 base low readback");
    read_chk(2'd3, 32'h0000_0003, "R9 ext base readback");

    reg_write(2'd0, 32'h0010_0121);
    read_chk(2'd0, 32'h0010_0121, "R4 mode readback");
    reg_write(2'd2, 32'h0000_2000);
    read_chk(2'd2, 32'h0000_1000, "R9 base locked while enabled");

    send_packet(36'h3_0000_1000, 32'hA500_0000, 1'b1, -1);
    read_chk(2'd1, 32'h0010_0010, "R3 full flags after store");
    chk(irq == 1'b1, "R8 irq on full", {63'd0, irq}, 64'd1);
    chk(summary == 32'h1, "R11 summary port-write", {32'd0, summary}, 64'h1);

    send_packet(36'h3_0000_1000, 32'hBB00_0000, 1'b0, -1);
    read_chk(2'd1, 32'h0010_0018, "R3 discard flag");
    chk(drop_cnt == 8'd1, "R3 drop count", {56'd0, drop_cnt}, 64'd1);

    reg_write(2'd1, 32'h0000_0008);
    read_chk(2'd1, 32'h0010_0010, "R5 clear discard");
    reg_write(2'd1, 32'h0000_0000);
    read_chk(2'd1, 32'h0010_0010, "R5 write zero no effect");
    reg_write(2'd1, 32'h0000_0010);
    read_chk(2'd1, 32'h0010_0000, "R5 clear full irq flag");
    chk(irq == 1'b0, "R8 irq drops", {63'd0, irq}, 64'd0);

    reg_write(2'd0, 32'h0010_0123);
    read_chk(2'd0, 32'h0010_0121, "R4 clear-queue reads zero");
    read_chk(2'd1, 32'h0000_0000, "R4 queue unlocked");

    send_packet(36'h3_0000_1000, 32'hC000_0000, 1'b1, 6);
    read_chk(2'd1, 32'h0000_0080, "R6 error flag, no full");
    chk(irq == 1'b1, "R8 irq on error", {63'd0, irq}, 64'd1);

    reg_write(2'd1, 32'h0000_0080);
    read_chk(2'd1, 32'h0000_0080, "R7 no clear while enabled");
    reg_write(2'd0, 32'h0010_0120);
    reg_write(2'd1, 32'h0000_0080);
    read_chk(2'd1, 32'h0000_0000, "R7 clear while disabled");

    send_packet(36'h3_0000_1000, 32'hD000_0000, 1'b0, -1);
    read_chk(2'd1, 32'h0000_0000, "R10 disabled no flags");
    chk(drop_cnt == 8'd1, "R10 drop count unchanged", {56'd0, drop_cnt}, 64'd1);

    reg_write(2'd2, 32'h0000_2040);
    read_chk(2'd2, 32'h0000_2040, "R9 base write while disabled");

    port1_err = 1'b1; msg_err = 1'b1; #1;
    chk(summary == 32'h8000_0002, "R11 summary errors", {32'd0, summary}, 64'h8000_0002);
    port1_err = 1'b0; msg_err = 1'b0; port2_err = 1'b1; #1;
    chk(summary == 32'h4000_0000, "R11 summary port2", {32'd0, summary}, 64'h4000_0000);
    port2_err = 1'b0;

    reg_write(2'd0, 32'h0000_0101);
    send_packet(36'h3_0000_2040, 32'h1234_0000, 1'b1, -1);
    read_chk(2'd1, 32'h0010_0010, "R2 second base stored");
    chk(exp_addr.size() == 0, "R2 all expected writes seen", 64'(exp_addr.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule